// File: doc/BRIEF.md
# Addressable LED Chain Serializer

This block drives the data line of a single-wire chain of addressable RGB LEDs. A host pushes colour words into a small input queue. The block moves the word at the head of the queue into a left-shifting register and sends it out one bit at a time, most significant bit first. Every data bit takes three slots of an external 2.4 MHz tick enable. The first slot is always high, the second carries the bit, and the third is always low. A 24-bit pixel therefore lasts 30 us and a 32-bit pixel lasts 40 us. The width is chosen per word at the time it is written, so three-colour and four-colour LEDs can share the same chain logic.

The block keeps sending words back to back for as long as the queue holds data. When the queue drains to half its depth, a level flag and a one-cycle interrupt pulse tell the host to refill it. When the queue is empty after the final low slot, the frame is treated as finished. The line then stays low and the busy flag drops. The host is responsible for the latch gap that separates frames.

Top module: `led_chain_tx`

## Requirements
- R1: After reset, serOut is 0, busy is 0, irq is 0, ovf is 0 and halfLow is 1.
- R2: A word written with wrWide=0 is sent as its 24 bits wrData[23:0], starting with bit 23 and ending with bit 0.
- R3: Each data bit is sent as three consecutive tick slots with the values 1, then the bit value, then 0.
- R4: serOut is registered. It changes only on a clock edge where tickEn is 1 and holds its value on every other edge.
- R5: While the queue holds data, the next word starts on the tick that ends the previous word's last low slot. busy stays 1 throughout, with no idle slot between words.
- R6: A word written with wrWide=1 is sent as all 32 bits of wrData, starting with bit 31.
- R7: halfLow is 1 whenever the queue holds FIFO_DEPTH/2 words or fewer. irq is a one-cycle pulse in the cycle after a read, with no write in the same cycle, takes the level from FIFO_DEPTH/2+1 down to FIFO_DEPTH/2.
- R8: A write while the queue holds FIFO_DEPTH words is dropped and sets the sticky flag ovf. A 1 on ovfClr clears ovf, and a new overflow in the same cycle takes precedence over the clear.
- R9: When the queue is empty at the end of a word's last low slot, busy drops on that tick and serOut stays 0 until new data is sent.
- R10: From idle, a write alone does not start sending. The first tick after the write makes serOut and busy 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle enable at 2.4 MHz that marks slot boundaries |
| wrEn | input | 1 | Push a word into the queue |
| wrData | input | 32 | Colour word to push; only bits 23:0 are used when wrWide is 0 |
| wrWide | input | 1 | 1 = send 32 bits for this word, 0 = send 24 bits |
| ovfClr | input | 1 | Clears the overflow flag when 1 |
| serOut | output | 1 | Serial data line to the LED chain |
| busy | output | 1 | A frame is being sent |
| halfLow | output | 1 | Queue level is at or below half depth |
| irq | output | 1 | Refill request pulse |
| ovf | output | 1 | Sticky flag for a dropped write |

## Verification
On every cycle, the assertions check the following:
- The line holds its value between ticks.
- The line is low whenever busy is low.
- Words are read only from a non-empty queue.
- The queue level never exceeds its depth.
- Every write to a full queue sets ovf.
- irq never pulses while the level is above half.

Other behaviour can only be shown by the bench's scenarios, which compare the captured slot stream with the expected stream. These scenarios cover the exact slot contents and bit order, the choice of 24 or 32 bits per word, the absence of gaps between words, the dropped ninth word, the count of refill pulses, and the tick on which busy falls.

// File: rtl/led_tx_pkg.sv
package led_tx_pkg;
  typedef enum logic [1:0] {
    OUT_HOLD = 2'd0,
    OUT_HIGH = 2'd1,
    OUT_DATA = 2'd2,
    OUT_LOW  = 2'd3
  } outSel_e;

  typedef struct packed {
    logic    load;
    logic    shift;
    outSel_e outSel;
  } txStrobe_t;
endpackage

// File: rtl/led_tx_datapath.sv
module led_tx_datapath
  import led_tx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int NARROW_BITS = 24,
  parameter int WIDE_BITS   = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [WIDE_BITS-1:0] wrData,
  input  logic                 wrWide,
  input  logic                 ovfClr,
  input  txStrobe_t            st,
  output logic                 fifoEmpty,
  output logic                 curWide,
  output logic                 serOut,
  output logic                 halfLow,
  output logic                 irq,
  output logic                 ovf
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int PAD_W = WIDE_BITS - NARROW_BITS;
  localparam int ENT_W = WIDE_BITS + 1;
  localparam logic [CNT_W-1:0] FULL_LVL  = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] HALF_LVL  = CNT_W'(FIFO_DEPTH / 2);
  localparam logic [CNT_W-1:0] ABOVE_HALF = CNT_W'(FIFO_DEPTH / 2 + 1);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(FIFO_DEPTH - 1);

  logic [ENT_W-1:0]     mem [FIFO_DEPTH];
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]     count;
  logic [WIDE_BITS-1:0] shiftReg;
  logic                 fifoFull, doPush, doPop;
  logic [ENT_W-1:0]     headEntry;

  assign fifoFull  = (count == FULL_LVL);
  assign fifoEmpty = (count == '0);
  assign doPush    = wrEn && !fifoFull;
  assign doPop     = st.load && !fifoEmpty;
  assign halfLow   = (count <= HALF_LVL);
  assign headEntry = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {wrWide, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      irq   <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      irq <= doPop && !doPush && (count == ABOVE_HALF);
      if (wrEn && fifoFull) ovf <= 1'b1;
      else if (ovfClr)      ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      curWide  <= 1'b0;
      serOut   <= 1'b0;
    end else begin
      if (doPop) begin
        curWide  <= headEntry[WIDE_BITS];
        shiftReg <= headEntry[WIDE_BITS] ? headEntry[WIDE_BITS-1:0]
                                         : {headEntry[NARROW_BITS-1:0], {PAD_W{1'b0}}};
      end else if (st.shift) begin
        shiftReg <= {shiftReg[WIDE_BITS-2:0], 1'b0};
      end
      case (st.outSel)
        OUT_HIGH: serOut <= 1'b1;
        OUT_DATA: serOut <= shiftReg[WIDE_BITS-1];
        OUT_LOW:  serOut <= 1'b0;
        default:  serOut <= serOut;
      endcase
    end
  end

  // R8: the queue level never exceeds its depth
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_LVL);
  // R8: a write to a full queue always leaves ovf set
  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fifoFull) |=> ovf);
  // R7: the refill pulse only appears at or below half level
  assert_irq_half_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> halfLow);
endmodule

// File: rtl/led_tx_ctrl.sv
module led_tx_ctrl
  import led_tx_pkg::*;
#(
  parameter int NARROW_BITS = 24,
  parameter int WIDE_BITS   = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      fifoEmpty,
  input  logic      curWide,
  output txStrobe_t st,
  output logic      busy
);
  localparam int BIT_W = $clog2(WIDE_BITS);
  localparam logic [BIT_W-1:0] LAST_NARROW = BIT_W'(NARROW_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_WIDE   = BIT_W'(WIDE_BITS - 1);

  logic [1:0]       slot;
  logic [BIT_W-1:0] bitIdx;
  logic             lastBit;

  assign lastBit = (bitIdx == (curWide ? LAST_WIDE : LAST_NARROW));

  always_comb begin
    st = '{load: 1'b0, shift: 1'b0, outSel: OUT_HOLD};
    if (tickEn) begin
      if (!busy) begin
        if (!fifoEmpty) begin
          st.load   = 1'b1;
          st.outSel = OUT_HIGH;
        end
      end else begin
        case (slot)
          2'd0: st.outSel = OUT_DATA;
          2'd1: st.outSel = OUT_LOW;
          default: begin
            if (!lastBit) begin
              st.shift  = 1'b1;
              st.outSel = OUT_HIGH;
            end else if (!fifoEmpty) begin
              st.load   = 1'b1;
              st.outSel = OUT_HIGH;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      slot   <= 2'd0;
      bitIdx <= '0;
    end else if (tickEn) begin
      if (!busy) begin
        if (!fifoEmpty) begin
          busy   <= 1'b1;
          slot   <= 2'd0;
          bitIdx <= '0;
        end
      end else if (slot != 2'd2) begin
        slot <= slot + 2'd1;
      end else begin
        slot <= 2'd0;
        if (!lastBit)         bitIdx <= bitIdx + 1'b1;
        else if (!fifoEmpty)  bitIdx <= '0;
        else                  busy   <= 1'b0;
      end
    end
  end

  // R5: a word is only taken from a non-empty queue
  assert_load_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.load |-> !fifoEmpty);
  // R4: the line is only driven on a tick
  assert_drive_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.outSel != OUT_HOLD) |-> tickEn);
endmodule

// File: rtl/led_chain_tx.sv
module led_chain_tx
  import led_tx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int NARROW_BITS = 24,
  parameter int WIDE_BITS   = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 wrEn,
  input  logic [WIDE_BITS-1:0] wrData,
  input  logic                 wrWide,
  input  logic                 ovfClr,
  output logic                 serOut,
  output logic                 busy,
  output logic                 halfLow,
  output logic                 irq,
  output logic                 ovf
);
  txStrobe_t strobe;
  logic      fifoEmpty, curWide;

  led_tx_ctrl #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .fifoEmpty(fifoEmpty),
    .curWide(curWide), .st(strobe), .busy(busy)
  );

  led_tx_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .NARROW_BITS(NARROW_BITS),
                    .WIDE_BITS(WIDE_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrWide(wrWide),
    .ovfClr(ovfClr), .st(strobe), .fifoEmpty(fifoEmpty), .curWide(curWide),
    .serOut(serOut), .halfLow(halfLow), .irq(irq), .ovf(ovf)
  );

  // R4: the line holds its value on every edge without a tick
  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(serOut));
  // R9: the line is low whenever no frame is in progress
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !serOut);
endmodule

// File: tb/led_chain_tx_tb_top.sv
module led_chain_tx_tb_top;
  localparam int TP = 4;
  localparam int NV = 6;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 32'h00A5FF00}, {1'b0, 32'h00000001}, {1'b1, 32'h80000001},
    {1'b0, 32'h00FFFFFF}, {1'b1, 32'hDEADBEEF}, {1'b0, 32'h00123456}
  };

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, wrEn = 1'b0, wrWide = 1'b0, ovfClr = 1'b0;
  logic [31:0] wrData = '0;
  logic serOut, busy, halfLow, irq, ovf;

  int checkCount = 0, failCount = 0, cycles = 0;
  bit tickRun = 1'b0;
  int tickDiv = 0;
  logic prevTick = 1'b0, lastOut = 1'b0;
  bit cap [4096];
  int capN = 0, irqCount = 0, changeErr = 0;
  logic [32:0] sent [16];
  int nSent = 0;

  always #10 clk = ~clk;

  led_chain_tx dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .wrWide(wrWide), .ovfClr(ovfClr), .serOut(serOut), .busy(busy),
    .halfLow(halfLow), .irq(irq), .ovf(ovf)
  );

  always @(negedge clk) begin
    if (!tickRun) begin
      tickDiv = 0;
      tickEn  = 1'b0;
    end else begin
      tickEn  = (tickDiv == TP - 1);
      tickDiv = (tickDiv == TP - 1) ? 0 : tickDiv + 1;
    end
  end

  always @(posedge clk) prevTick <= tickEn;

  always @(negedge clk) begin
    if (rstN) begin
      if (serOut !== lastOut && !prevTick) changeErr++;
      if (prevTick && busy === 1'b1 && capN < 4096) begin
        cap[capN] = serOut;
        capN++;
      end
      if (irq === 1'b1) irqCount++;
    end
    lastOut = serOut;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushWord(input logic [32:0] w);
    @(negedge clk);
    wrEn = 1'b1; wrWide = w[32]; wrData = w[31:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runUntilIdle();
    tickRun = 1'b1;
    while (busy !== 1'b1) @(negedge clk);
    while (busy !== 1'b0) @(negedge clk);
    repeat (10 * TP) @(negedge clk);
    tickRun = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // compare captured slots against the words in sent[]
  task automatic compareStream(input string tag);
    int pos = 0;
    for (int w = 0; w < nSent; w++) begin
      int nb = sent[w][32] ? 32 : 24;
      logic [31:0] al = sent[w][32] ? sent[w][31:0] : {sent[w][23:0], 8'h00};
      int bad = -1;
      logic [31:0] gotW = '0, expW = '0;
      for (int k = 0; k < nb; k++) begin
        for (int s = 0; s < 3; s++) begin
          bit e = (s == 0) ? 1'b1 : (s == 1) ? al[31 - k] : 1'b0;
          bit g = (pos < capN) ? cap[pos] : 1'b0;
          if (s == 1) begin
            gotW = {gotW[30:0], g};
            expW = {expW[30:0], e};
          end
          if (g != e && bad < 0) bad = pos;
          pos++;
        end
      end
      chk(bad < 0, sent[w][32] ? "R6/R3" : "R2/R3",
          $sformatf("%s word %0d slot stream (first bad slot %0d)", tag, w, bad), gotW, expW);
    end
    chk(capN == pos, "R5/R9", {tag, " total busy slots"}, capN, pos);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(serOut === 1'b0, "R1", "serOut after reset", serOut, 0);
    chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
    chk(irq === 1'b0, "R1", "irq after reset", irq, 0);
    chk(ovf === 1'b0, "R1", "ovf after reset", ovf, 0);
    chk(halfLow === 1'b1, "R1", "halfLow after reset", halfLow, 1);

    // table walk: mixed widths back to back
    nSent = 0;
    for (int i = 0; i < NV; i++) begin
      pushWord(VEC[i]);
      sent[nSent] = VEC[i];
      nSent++;
    end
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && serOut === 1'b0, "R10", "no start before tick", {busy, serOut}, 0);
    chk(halfLow === 1'b0, "R7", "halfLow with 6 of 8", halfLow, 0);
    capN = 0; irqCount = 0; changeErr = 0;
    runUntilIdle();
    chk(capN > 0 && cap[0] == 1'b1, "R10", "first tick drives high with busy", capN > 0 ? cap[0] : 0, 1);
    compareStream("table");
    chk(irqCount == 1, "R7", "refill pulses", irqCount, 1);
    chk(halfLow === 1'b1, "R7", "halfLow when drained", halfLow, 1);
    chk(changeErr == 0, "R4", "line changes off tick", changeErr, 0);
    chk(busy === 1'b0 && serOut === 1'b0, "R9", "parked low after frame", {busy, serOut}, 0);

    // overflow: nine writes into eight entries
    nSent = 0;
    for (int i = 0; i < 9; i++) begin
      logic [32:0] w = {1'b0, 8'h00, 8'(i * 37 + 5), 8'(~i), 8'(i)};
      pushWord(w);
      if (i < 8) begin
        sent[nSent] = w;
        nSent++;
      end
    end
    @(negedge clk);
    chk(ovf === 1'b1, "R8", "ovf after write to full", ovf, 1);
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    @(negedge clk);
    chk(ovf === 1'b0, "R8", "ovf cleared", ovf, 0);
    capN = 0; irqCount = 0; changeErr = 0;
    runUntilIdle();
    compareStream("overflow");
    chk(irqCount == 1, "R7", "refill pulses after full", irqCount, 1);
    chk(changeErr == 0, "R4", "line changes off tick (overflow run)", changeErr, 0);
    chk(ovf === 1'b0, "R8", "ovf stays clear", ovf, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule